// File: doc/BRIEF.md
# Quad-Channel DDR Sample Deinterleaver

This block sits behind the receivers of a 16-bit double-data-rate sample bus. The bus carries four interleaved 16-bit channels (A to D). A word is taken on every rising and every falling clock edge. Two consecutive edges form a pair, and two pairs make one complete four-channel sample. Each complete sample is put out in parallel on four channel ports, with a one-cycle valid strobe.

The bus has two layouts, chosen by a plain mode input:
- **Word-wide:** each edge carries one whole channel word.
- **Byte-wide:** the bus splits into two byte lanes, and each lane serialises two channels a byte at a time.

A single framing input (`frm`) does two jobs:
- Sampled high on a rising edge, it marks the start of a sample. This realigns the assembler and, in byte-wide mode, is what establishes the sample boundaries in the first place.
- When parity checking is enabled, its value on the falling edge that follows is the even-parity bit for the next block of samples. A mismatch raises a sticky error flag.

The output side is a valid-only stream with no back-pressure. The upstream source cannot be stalled, so `out_vld` carries no ready. The consumer must take the channel values in the cycle where `out_vld` is high. The channel ports hold their value until the next strobe.

Top module: `quad_ddr_deint`

## Requirements
- R1: A bus word is captured on every rising and every falling edge of `clk`. In each pair, the rising-edge word comes before the falling-edge word. The mode and parity-enable inputs are sampled together with each rising-edge word.
- R2: With `wide_mode`=1, successive words are channel A, B, C, D of one sample, in that order, each word being the whole 16-bit channel value.
- R3: With `wide_mode`=0, `din[15:8]` carries A-high, A-low, B-high, B-low on four successive edges. `din[7:0]` carries C-high, C-low, D-high, D-low on the same edges. The high byte of each channel is bits [15:8] of that channel.
- R4: `frm` sampled high on a rising edge makes the word captured on that edge the first word of a new sample. Any partly assembled sample is dropped.
- R5: In word-wide mode, the first rising edge after reset release carries word A without any sync.
- R6: In byte-wide mode, no `out_vld` is produced until `frm` has been sampled high on a rising edge since reset.
- R7: `out_vld` is high for exactly one cycle per sample. It rises on the first rising edge after the sample's last word. `ch_a`..`ch_d` change only together with `out_vld` and hold their value otherwise.
- R8: If `par_en` is 1 when a sync is taken, the value of `frm` on the next falling edge is the parity bit for the block of `BLK_SAMPLES` samples starting at that sync. At the block's end, `par_err` is set if the XOR of the parity bit and every data bit of the block is 1 (even parity).
- R9: `par_err` stays set until `clr_err` is sampled high (a new mismatch in the same cycle wins). A block started with `par_en`=0 is never checked. A sync arriving before a block ends abandons that block unchecked.
- R10: While `rst_n` is low, `out_vld`, `par_err` and all channel outputs are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Interface clock; data taken on both edges |
| rst_n | input | 1 | Synchronous active-low reset |
| wide_mode | input | 1 | 1 = word-wide layout, 0 = byte-wide layout |
| par_en | input | 1 | Enables block parity checking at the next sync |
| clr_err | input | 1 | Clears the sticky parity error |
| din | input | 16 | DDR sample bus |
| frm | input | 1 | Sync on rising edge, parity bit on following falling edge |
| out_vld | output | 1 | One-cycle strobe: a complete sample is on the channel ports |
| ch_a | output | 16 | Channel A sample |
| ch_b | output | 16 | Channel B sample |
| ch_c | output | 16 | Channel C sample |
| ch_d | output | 16 | Channel D sample |
| par_err | output | 1 | Sticky block parity mismatch flag |

## Verification
The bench targets the following corner cases:
- **Mode switching and sync:** a stream that switches between the two layouts sample by sample, with syncs both on and off sample boundaries. A design that tracked the mode per sample instead of per word would garble the sample at each switch.
- **Mid-sample resync:** a sync placed after half a sample must discard the half. Otherwise the output is a mix of stale A/B and fresh words.
- **Byte-wide start-up:** before any sync, byte-wide traffic must produce no output. A design that started blind would emit misaligned byte pairs.
- **Parity:**
  - Blocks with correct and with flipped parity.
  - Clearing of the sticky flag.
  - A block sent with checking disabled.
  - A short block interrupted by a new sync. A design that did not restart the accumulator on sync would flag a good block.

// File: rtl/qdd_pkg.sv
package qdd_pkg;
  localparam int NCH = 4;

  typedef enum logic {
    MODE_BYTE = 1'b0,
    MODE_WORD = 1'b1
  } bus_mode_e;
endpackage

// File: rtl/qdd_edge_cap.sv
// Captures one bus word per clock edge and the framing input on both edges.
module qdd_edge_cap #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] din,
  input  logic         frm,
  input  logic         wide_in,
  input  logic         pen_in,
  output logic [W-1:0] rise_w,
  output logic [W-1:0] fall_w,
  output logic         sync_r,
  output logic         par_f,
  output logic         wide_r,
  output logic         pen_r,
  output logic         pair_ok
);
  // rising-edge half of the pair, with the controls that travel with it
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rise_w  <= '0;
      sync_r  <= 1'b0;
      wide_r  <= 1'b0;
      pen_r   <= 1'b0;
      pair_ok <= 1'b0;
    end else begin
      rise_w  <= din;
      sync_r  <= frm;
      wide_r  <= wide_in;
      pen_r   <= pen_in;
      pair_ok <= 1'b1;
    end
  end

  // falling-edge half of the pair; frm here is the candidate parity bit
  always_ff @(negedge clk) begin
    if (!rst_n) begin
      fall_w <= '0;
      par_f  <= 1'b0;
    end else begin
      fall_w <= din;
      par_f  <= frm;
    end
  end
endmodule

// File: rtl/qdd_assembler.sv
// Turns a stream of word pairs into complete four-channel samples.
module qdd_assembler
  import qdd_pkg::*;
#(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         pair_ok,
  input  logic         sync,
  input  logic         wide,
  input  logic [W-1:0] first_w,
  input  logic [W-1:0] second_w,
  output logic         smp_vld,
  output logic [W-1:0] ch_q [NCH],
  output logic         go,
  output logic         start,
  output logic         smp_end
);
  localparam int H = W / 2;

  bus_mode_e   mode;
  logic        ph;
  logic        locked;
  logic        ph_eff;
  logic        open_q;
  logic [W-1:0] hi_w;
  logic [W-1:0] lo_w;

  assign mode    = wide ? MODE_WORD : MODE_BYTE;
  assign start   = pair_ok & sync;
  assign ph_eff  = start ? 1'b0 : ph;
  // byte layout has no defined boundary until a sync has been seen
  assign open_q  = locked | start | (mode == MODE_WORD);
  assign go      = pair_ok & open_q;
  assign smp_end = go & ph_eff;

  // byte lanes: high byte on the first edge, low byte on the second
  assign hi_w = {first_w[W-1:H], second_w[W-1:H]};
  assign lo_w = {first_w[H-1:0], second_w[H-1:0]};

  generate
    for (genvar g = 0; g < NCH; g++) begin : g_slot
      localparam bit PH_WORD = ((g / 2) == 1);
      localparam bit PH_BYTE = ((g % 2) == 1);
      localparam bit IS_EVEN = ((g % 2) == 0);
      localparam bit IS_UPPER = (g < 2);

      logic         slot_ph;
      logic [W-1:0] slot_v;
      logic [W-1:0] hold_r;
      logic [W-1:0] out_r;

      always_comb begin
        if (mode == MODE_WORD) begin
          slot_ph = PH_WORD;
          slot_v  = IS_EVEN ? first_w : second_w;
        end else begin
          slot_ph = PH_BYTE;
          slot_v  = IS_UPPER ? hi_w : lo_w;
        end
      end

      always_ff @(posedge clk) begin
        if (!rst_n) begin
          hold_r <= '0;
          out_r  <= '0;
        end else if (go) begin
          if (!ph_eff) begin
            hold_r <= slot_v;
          end else begin
            out_r <= slot_ph ? slot_v : hold_r;
          end
        end
      end

      assign ch_q[g] = out_r;
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ph      <= 1'b0;
      locked  <= 1'b0;
      smp_vld <= 1'b0;
    end else begin
      smp_vld <= smp_end;
      locked  <= locked | start;
      if (go) begin
        ph <= ~ph_eff;
      end
    end
  end
endmodule

// File: rtl/qdd_blk_parity.sv
// Even parity over a block of samples, checked against the bit sent at sync.
module qdd_blk_parity #(
  parameter int W   = 16,
  parameter int BLK = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         go,
  input  logic         start,
  input  logic         smp_end,
  input  logic         par_en,
  input  logic         par_bit,
  input  logic         clr_err,
  input  logic [W-1:0] first_w,
  input  logic [W-1:0] second_w,
  output logic         par_err
);
  localparam int CW = (BLK > 1) ? $clog2(BLK) : 1;
  localparam logic [CW-1:0] LAST_IDX = CW'(BLK - 1);

  logic          armed;
  logic          pbit;
  logic          acc;
  logic [CW-1:0] cnt;
  logic          pair_x;
  logic          acc_nx;
  logic          blk_last;
  logic          mism;

  assign pair_x   = ^{first_w, second_w};
  assign acc_nx   = start ? pair_x : (acc ^ pair_x);
  assign blk_last = smp_end & (cnt == LAST_IDX);
  assign mism     = go & armed & blk_last & (acc_nx ^ pbit);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      armed <= 1'b0;
      pbit  <= 1'b0;
      acc   <= 1'b0;
      cnt   <= '0;
    end else if (go) begin
      acc <= acc_nx;
      if (start) begin
        armed <= par_en;
        pbit  <= par_bit;
        cnt   <= '0;
      end else if (smp_end) begin
        if (blk_last) begin
          armed <= 1'b0;
        end else begin
          cnt <= cnt + 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      par_err <= 1'b0;
    end else begin
      par_err <= (par_err & ~clr_err) | mism;
    end
  end
endmodule

// File: rtl/quad_ddr_deint.sv
module quad_ddr_deint
  import qdd_pkg::*;
#(
  parameter int SMP_W       = 16,
  parameter int BLK_SAMPLES = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wide_mode,
  input  logic             par_en,
  input  logic             clr_err,
  input  logic [SMP_W-1:0] din,
  input  logic             frm,
  output logic             out_vld,
  output logic [SMP_W-1:0] ch_a,
  output logic [SMP_W-1:0] ch_b,
  output logic [SMP_W-1:0] ch_c,
  output logic [SMP_W-1:0] ch_d,
  output logic             par_err
);
  logic [SMP_W-1:0] rise_w;
  logic [SMP_W-1:0] fall_w;
  logic             sync_r;
  logic             par_f;
  logic             wide_r;
  logic             pen_r;
  logic             pair_ok;
  logic [SMP_W-1:0] ch_q [NCH];
  logic             go;
  logic             start;
  logic             smp_end;

  qdd_edge_cap #(.W(SMP_W)) u_cap (
    .clk     (clk),
    .rst_n   (rst_n),
    .din     (din),
    .frm     (frm),
    .wide_in (wide_mode),
    .pen_in  (par_en),
    .rise_w  (rise_w),
    .fall_w  (fall_w),
    .sync_r  (sync_r),
    .par_f   (par_f),
    .wide_r  (wide_r),
    .pen_r   (pen_r),
    .pair_ok (pair_ok)
  );

  qdd_assembler #(.W(SMP_W)) u_asm (
    .clk      (clk),
    .rst_n    (rst_n),
    .pair_ok  (pair_ok),
    .sync     (sync_r),
    .wide     (wide_r),
    .first_w  (rise_w),
    .second_w (fall_w),
    .smp_vld  (out_vld),
    .ch_q     (ch_q),
    .go       (go),
    .start    (start),
    .smp_end  (smp_end)
  );

  qdd_blk_parity #(.W(SMP_W), .BLK(BLK_SAMPLES)) u_par (
    .clk      (clk),
    .rst_n    (rst_n),
    .go       (go),
    .start    (start),
    .smp_end  (smp_end),
    .par_en   (pen_r),
    .par_bit  (par_f),
    .clr_err  (clr_err),
    .first_w  (rise_w),
    .second_w (fall_w),
    .par_err  (par_err)
  );

  assign ch_a = ch_q[0];
  assign ch_b = ch_q[1];
  assign ch_c = ch_q[2];
  assign ch_d = ch_q[3];
endmodule

// File: rtl/quad_ddr_deint_chk.sv
module quad_ddr_deint_chk #(
  parameter int W = 16
) (
  input logic         clk,
  input logic         rst_n,
  input logic         wide_mode,
  input logic         par_en,
  input logic         clr_err,
  input logic         frm,
  input logic         out_vld,
  input logic [W-1:0] ch_a,
  input logic [W-1:0] ch_d,
  input logic         par_err
);
  logic seen_sync;
  logic ever_wide;
  logic ever_par;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      seen_sync <= 1'b0;
      ever_wide <= 1'b0;
      ever_par  <= 1'b0;
    end else begin
      seen_sync <= seen_sync | frm;
      ever_wide <= ever_wide | wide_mode;
      ever_par  <= ever_par | par_en;
    end
  end

  AST_VLD_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    out_vld |=> !out_vld); // R7

  AST_HOLD_CHANNELS: assert property (@(posedge clk) disable iff (!rst_n)
    (!$stable(ch_a) || !$stable(ch_d)) |-> out_vld); // R7

  AST_BYTE_NEEDS_SYNC: assert property (@(posedge clk) disable iff (!rst_n)
    (!ever_wide && !seen_sync) |-> !out_vld); // R6

  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (par_err && !clr_err) |=> par_err); // R9

  AST_ERR_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
    !ever_par |-> !par_err); // R9
endmodule

bind quad_ddr_deint quad_ddr_deint_chk #(.W(SMP_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .wide_mode (wide_mode),
  .par_en    (par_en),
  .clr_err   (clr_err),
  .frm       (frm),
  .out_vld   (out_vld),
  .ch_a      (ch_a),
  .ch_d      (ch_d),
  .par_err   (par_err)
);

// File: tb/quad_ddr_deint_tb.sv
module quad_ddr_deint_tb;
  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 8;

  // {wide, sync, A, B, C, D}
  localparam logic [65:0] VEC [NVEC] = '{
    {1'b1, 1'b0, 64'h1111_2222_3333_4444},
    {1'b1, 1'b0, 64'hA5A5_5A5A_FFFF_0000},
    {1'b1, 1'b1, 64'h0123_4567_89AB_CDEF},
    {1'b1, 1'b0, 64'h8001_7FFE_00FF_FF00},
    {1'b0, 1'b1, 64'h1234_5678_9ABC_DEF0},
    {1'b0, 1'b0, 64'hAB12_CD34_EF56_0789},
    {1'b0, 1'b0, 64'hFFFF_0001_8000_7F7F},
    {1'b1, 1'b0, 64'hBEEF_CAFE_F00D_D00D}
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wide_mode = 1'b1;
  logic        par_en = 1'b0;
  logic        clr_err = 1'b0;
  logic [15:0] din = '0;
  logic        frm = 1'b0;
  logic        out_vld;
  logic [15:0] ch_a, ch_b, ch_c, ch_d;
  logic        par_err;

  int nchk = 0;
  int nfail = 0;
  logic [63:0] rxq [$];

  always #(CLK_PERIOD / 2) clk = ~clk;

  quad_ddr_deint u_dut (
    .clk       (clk),
    .rst_n     (rst_n),
    .wide_mode (wide_mode),
    .par_en    (par_en),
    .clr_err   (clr_err),
    .din       (din),
    .frm       (frm),
    .out_vld   (out_vld),
    .ch_a      (ch_a),
    .ch_b      (ch_b),
    .ch_c      (ch_c),
    .ch_d      (ch_d),
    .par_err   (par_err)
  );

  // sample the strobe mid-cycle, away from the active edge
  always @(negedge clk) begin
    if (rst_n && out_vld) rxq.push_back({ch_a, ch_b, ch_c, ch_d});
  end

  task automatic chk(input bit ok, input string req, input logic [63:0] act,
                     input logic [63:0] exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  // entered and left at falling edge + 2
  task automatic drive_pair(input logic [15:0] w0, input logic f0,
                            input logic [15:0] w1, input logic f1);
    din = w0; frm = f0;
    @(posedge clk); #2;
    din = w1; frm = f1;
    @(negedge clk); #2;
  endtask

  task automatic drive_smp(input logic wide, input logic sync, input logic par,
                           input logic [63:0] s);
    logic [15:0] a, b, c, d;
    {a, b, c, d} = s;
    wide_mode = wide;
    if (wide) begin
      drive_pair(a, sync, b, par);
      drive_pair(c, 1'b0, d, 1'b0);
    end else begin
      drive_pair({a[15:8], c[15:8]}, sync, {a[7:0], c[7:0]}, par);
      drive_pair({b[15:8], d[15:8]}, 1'b0, {b[7:0], d[7:0]}, 1'b0);
    end
  endtask

  task automatic do_reset(input logic wide);
    rst_n = 1'b0; din = '0; frm = 1'b0; clr_err = 1'b0; wide_mode = wide;
    repeat (3) @(negedge clk);
    #2;
    rxq.delete();
    rst_n = 1'b1;
  endtask

  function automatic logic [63:0] smp_val(input int k);
    return 64'h0123_4567_89AB_CDEF ^ (64'(k) * 64'h0001_0003_0007_000B);
  endfunction

  task automatic drive_blk(input int n, input logic bad);
    logic p = 1'b0;
    for (int k = 0; k < n; k++) p ^= ^smp_val(k);
    for (int k = 0; k < n; k++)
      drive_smp(1'b1, k == 0, (k == 0) ? (p ^ bad) : 1'b0, smp_val(k));
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    nfail++;
    $display("FAIL R7 watchdog act=running exp=finished");
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end

  initial begin
    logic [63:0] s;
    // R10: outputs cleared in reset
    rst_n = 1'b0;
    repeat (4) @(negedge clk);
    chk(out_vld == 1'b0, "R10 out_vld", 64'(out_vld), 64'd0);
    chk(par_err == 1'b0, "R10 par_err", 64'(par_err), 64'd0);
    chk({ch_a, ch_b, ch_c, ch_d} == 64'd0, "R10 channels", {ch_a, ch_b, ch_c, ch_d}, 64'd0);

    // vector table: word stream from reset (R5), syncs (R4), byte lanes (R3)
    do_reset(1'b1);
    for (int i = 0; i < NVEC; i++)
      drive_smp(VEC[i][65], VEC[i][64], 1'b0, VEC[i][63:0]);
    drive_smp(1'b1, 1'b0, 1'b0, 64'd0);
    drive_smp(1'b1, 1'b0, 1'b0, 64'd0);
    chk(rxq.size() >= NVEC, "R5 sample count", 64'(rxq.size()), 64'(NVEC));
    for (int i = 0; i < NVEC; i++) begin
      s = (i < rxq.size()) ? rxq[i] : 64'hX;
      chk(s === VEC[i][63:0], VEC[i][65] ? "R2 word-wide sample" : "R3 byte-wide sample",
          s, VEC[i][63:0]);
    end

    // R7 / R1: latency, one-cycle strobe, hold
    do_reset(1'b1);
    drive_smp(1'b1, 1'b1, 1'b0, 64'hC001_D00D_1234_ABCD);
    @(posedge clk); #1;
    chk(out_vld == 1'b1, "R7 strobe after last word", 64'(out_vld), 64'd1);
    chk({ch_a, ch_b, ch_c, ch_d} == 64'hC001_D00D_1234_ABCD, "R1 edge order",
        {ch_a, ch_b, ch_c, ch_d}, 64'hC001_D00D_1234_ABCD);
    @(posedge clk); #1;
    chk(out_vld == 1'b0, "R7 strobe one cycle", 64'(out_vld), 64'd0);
    chk({ch_a, ch_b, ch_c, ch_d} == 64'hC001_D00D_1234_ABCD, "R7 hold",
        {ch_a, ch_b, ch_c, ch_d}, 64'hC001_D00D_1234_ABCD);
    @(negedge clk); #2;

    // R4: resync mid-sample drops the half sample
    do_reset(1'b1);
    drive_pair(16'h0BAD, 1'b1, 16'h0BAD, 1'b0);
    drive_smp(1'b1, 1'b1, 1'b0, 64'h5555_6666_7777_8888);
    drive_smp(1'b1, 1'b0, 1'b0, 64'd0);
    s = (rxq.size() > 0) ? rxq[0] : 64'hX;
    chk(s === 64'h5555_6666_7777_8888, "R4 resync", s, 64'h5555_6666_7777_8888);

    // R6: byte mode silent until sync
    do_reset(1'b0);
    for (int k = 0; k < 3; k++) drive_smp(1'b0, 1'b0, 1'b0, smp_val(k));
    drive_pair(16'h0, 1'b0, 16'h0, 1'b0);
    chk(rxq.size() == 0, "R6 no output before sync", 64'(rxq.size()), 64'd0);
    drive_smp(1'b0, 1'b1, 1'b0, 64'h3C3C_C3C3_0F0F_F0F0);
    drive_smp(1'b0, 1'b0, 1'b0, 64'd0);
    s = (rxq.size() > 0) ? rxq[0] : 64'hX;
    chk(s === 64'h3C3C_C3C3_0F0F_F0F0, "R6 first sample after sync", s,
        64'h3C3C_C3C3_0F0F_F0F0);

    // R8 / R9: block parity
    do_reset(1'b1);
    par_en = 1'b1;
    drive_blk(8, 1'b0);
    drive_pair(16'h0, 1'b0, 16'h0, 1'b0);
    chk(par_err == 1'b0, "R8 good parity", 64'(par_err), 64'd0);
    drive_blk(8, 1'b1);
    drive_pair(16'h0, 1'b0, 16'h0, 1'b0);
    chk(par_err == 1'b1, "R8 bad parity", 64'(par_err), 64'd1);
    repeat (3) drive_pair(16'h0, 1'b0, 16'h0, 1'b0);
    chk(par_err == 1'b1, "R9 sticky", 64'(par_err), 64'd1);
    clr_err = 1'b1;
    @(negedge clk); #2;
    clr_err = 1'b0;
    chk(par_err == 1'b0, "R9 clear", 64'(par_err), 64'd0);
    par_en = 1'b0;
    drive_blk(8, 1'b1);
    drive_pair(16'h0, 1'b0, 16'h0, 1'b0);
    chk(par_err == 1'b0, "R9 disabled block unchecked", 64'(par_err), 64'd0);
    par_en = 1'b1;
    drive_blk(4, 1'b1);
    drive_blk(8, 1'b0);
    drive_pair(16'h0, 1'b0, 16'h0, 1'b0);
    chk(par_err == 1'b0, "R9 abandoned block", 64'(par_err), 64'd0);

    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end
endmodule